// File: doc/BRIEF.md
# Counter-Ramp Converter Sequencer

This block is the digital side of a counter-type analog-to-digital converter. An N-bit up-counter drives an external DAC. An analog comparator, also external, looks at the input voltage and the DAC level. Its output stays high while the input is still above the DAC level plus the comparator threshold, and it drops low once the DAC has climbed past that point. The comparator output therefore serves as an active-low end-of-conversion signal: counting is only allowed while it is high.

A start pulse clears the counter and holds it at zero for as long as start stays high. When start falls, the counter climbs by one code per clock through a synchronous count enable; the clock itself is never gated. It stops at the first code where the comparator reads low, and that code is the conversion result. The result stays in the counter until the next start pulse.

If the counter reaches all ones while the comparator is still high, the block stops at full scale and raises an out-of-range flag. Conversion time depends on the input level and is at most 2^N clocks.

A five-state machine sequences this work. The states are IDLE (after reset), CLEAR (start held), RAMP (counting), DONE (comparator tripped) and FULL (full scale reached). The transitions are:
- any state to CLEAR while start is high (restart);
- CLEAR to RAMP when start is low (launch);
- RAMP to DONE when the comparator reads low (trip);
- RAMP to FULL when the counter is all ones and the comparator is still high (saturate).

IDLE, DONE and FULL hold until the next start.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: After reset, `dac_code_o` is 0, `busy_o` is 0, `eoc_n_o` is 1, `range_o` is 0 and `result_o` is 0.
- R2: While `start_i` is high, the counter is cleared to 0 on every clock and does not count, whatever `cmp_i` does. `busy_o` is 0 during this time.
- R3: In the clocks after `start_i` falls, `busy_o` is high and `dac_code_o` rises by exactly 1 per clock while `cmp_i` is high.
- R4: In the first clock edge where `cmp_i` is low during counting, counting stops: `eoc_n_o` falls, `busy_o` falls, and `dac_code_o` keeps that code as the result.
- R5: After completion, `dac_code_o` and `result_o` hold their value and `eoc_n_o` stays low until the next start. Changes on `cmp_i` have no effect.
- R6: If `dac_code_o` is all ones and `cmp_i` is still high, the counter stops at all ones, `range_o` goes high and `eoc_n_o` falls. If the comparator trips exactly at all ones, `range_o` stays low.
- R7: With a comparator that trips at code T (T ≤ 2^N−1), `busy_o` is high for exactly T+1 clocks. A conversion that runs to full scale is busy for exactly 2^N clocks.
- R8: `result_o` is 0 whenever `eoc_n_o` is high, and equals the counter once `eoc_n_o` is low.
- R9: A start pulse during counting abandons the conversion, with no completion reported. The counter returns to 0, and the next conversion begins from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start: clears the counter and holds it while high |
| cmp_i | input | 1 | Comparator output; low means the DAC has passed the input (active-low end of conversion) |
| dac_code_o | output | WIDTH | Counter value driving the DAC; holds the result after completion |
| result_o | output | WIDTH | Final code, 0 until a conversion completes |
| eoc_n_o | output | 1 | End of conversion, active low; its falling edge marks completion |
| busy_o | output | 1 | High while counting |
| range_o | output | 1 | High when the conversion stopped at full scale without a trip |

## Verification
The bench goes after the extremes of the ramp. These are:
- a trip at code 0, which a design with an extra pipeline stage would overshoot to 1;
- a trip exactly at all ones, where a design that tests for saturation before the comparator would wrongly raise the range flag;
- inputs beyond full scale, where a counter that does not stop would wrap to zero.

It measures the busy time of every conversion, which exposes an off-by-one enable. It toggles the comparator after completion to catch a counter that keeps listening. It also aborts a conversion midway to make sure no stale completion is reported and the restart begins from zero.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CLEAR = 3'd1,
        ST_RAMP  = 3'd2,
        ST_DONE  = 3'd3,
        ST_FULL  = 3'd4
    } adc_state_e;
endpackage

// File: rtl/ramp_adc_counter.sv
module ramp_adc_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    output logic [WIDTH-1:0] cnt_o,
    output logic             at_max_o
);
    localparam logic [WIDTH-1:0] MAX_CODE = {WIDTH{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (en_i) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    assign at_max_o = (cnt_o == MAX_CODE);
endmodule

// File: rtl/ramp_adc_fsm.sv
module ramp_adc_fsm
    import ramp_adc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       cmp_i,
    input  logic       at_max_i,
    output adc_state_e state_o,
    output logic       cnt_clr_o,
    output logic       cnt_en_o
);
    adc_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_CLEAR;                       // restart
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_CLEAR: state_d = ST_RAMP;          // launch
                ST_RAMP: begin
                    if (!cmp_i) begin
                        state_d = ST_DONE;            // trip
                    end else if (at_max_i) begin
                        state_d = ST_FULL;            // saturate
                    end
                end
                ST_DONE:  state_d = ST_DONE;
                ST_FULL:  state_d = ST_FULL;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // counter controls
    always_comb begin
        cnt_clr_o = start_i;
        cnt_en_o  = 1'b0;
        unique case (state_q)
            ST_RAMP:  cnt_en_o = !start_i && cmp_i && !at_max_i;
            default:  cnt_en_o = 1'b0;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl
    import ramp_adc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_i,
    output logic [WIDTH-1:0] dac_code_o,
    output logic [WIDTH-1:0] result_o,
    output logic             eoc_n_o,
    output logic             busy_o,
    output logic             range_o
);
    adc_state_e       state;
    logic             cnt_clr;
    logic             cnt_en;
    logic             at_max;
    logic [WIDTH-1:0] cnt;

    ramp_adc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .cmp_i     (cmp_i),
        .at_max_i  (at_max),
        .state_o   (state),
        .cnt_clr_o (cnt_clr),
        .cnt_en_o  (cnt_en)
    );

    ramp_adc_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (cnt_clr),
        .en_i     (cnt_en),
        .cnt_o    (cnt),
        .at_max_o (at_max)
    );

    // output decode
    always_comb begin
        busy_o   = 1'b0;
        eoc_n_o  = 1'b1;
        range_o  = 1'b0;
        result_o = '0;
        unique case (state)
            ST_RAMP: busy_o = 1'b1;
            ST_DONE: begin
                eoc_n_o  = 1'b0;
                result_o = cnt;
            end
            ST_FULL: begin
                eoc_n_o  = 1'b0;
                range_o  = 1'b1;
                result_o = cnt;
            end
            default: busy_o = 1'b0;
        endcase
    end

    assign dac_code_o = cnt;
endmodule

// File: rtl/ramp_adc_checker.sv
module ramp_adc_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             cmp_i,
    input logic [WIDTH-1:0] dac_code_o,
    input logic [WIDTH-1:0] result_o,
    input logic             eoc_n_o,
    input logic             busy_o,
    input logic             range_o
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    assert_clear_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (dac_code_o == '0) && !busy_o);

    assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cmp_i && !start_i && dac_code_o != TOP)
            |=> dac_code_o == WIDTH'($past(dac_code_o) + 1'b1));

    assert_trip_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !cmp_i && !start_i) |=> (!eoc_n_o && !busy_o && $stable(dac_code_o)));

    assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!eoc_n_o && !start_i) |=> (!eoc_n_o && $stable(dac_code_o) && $stable(result_o)));

    assert_full_scale_R6: assert property (@(posedge clk) disable iff (!rst_n)
        range_o |-> (dac_code_o == TOP && !eoc_n_o));

    assert_result_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_n_o |-> (result_o == '0));

    assert_result_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc_n_o |-> (result_o == dac_code_o));
endmodule

bind ramp_adc_ctrl ramp_adc_checker #(.WIDTH(WIDTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .cmp_i      (cmp_i),
    .dac_code_o (dac_code_o),
    .result_o   (result_o),
    .eoc_n_o    (eoc_n_o),
    .busy_o     (busy_o),
    .range_o    (range_o)
);

// File: tb/ramp_adc_ctrl_tb_top.sv
`timescale 1ns/1ps
module ramp_adc_ctrl_tb_top;
    localparam int W    = 8;
    localparam int FULL = (1 << W) - 1;

    typedef struct {
        int res;
        bit ovr;
        int cyc;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         cmp;
    logic [W-1:0] code, result;
    logic         eoc_n, busy, rng;
    int           trip = 0;

    int   n_tests = 0;
    int   n_fail  = 0;
    exp_t exp_q[$];
    bit   finished = 0;

    always #2.5 clk = ~clk;

    // comparator model: high while the DAC code is below the trip code
    assign cmp = (int'(code) < trip);

    ramp_adc_ctrl #(.WIDTH(W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .cmp_i      (cmp),
        .dac_code_o (code),
        .result_o   (result),
        .eoc_n_o    (eoc_n),
        .busy_o     (busy),
        .range_o    (rng)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor / scoreboard
    int   busy_cnt  = 0;
    bit   prev_eoc  = 1'b1;
    bit   prev_busy = 1'b0;
    int   prev_code = 0;
    bit   step_bad  = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) begin
                busy_cnt++;
                if (prev_busy && int'(code) != prev_code + 1) step_bad = 1'b1;
            end
            if (!busy && eoc_n) begin
                busy_cnt = 0;
                step_bad = 1'b0;
            end
            if (prev_eoc && !eoc_n) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected completion", int'(code), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(int'(code) == e.res, "R4 result code", int'(code), e.res);
                    check(int'(result) == e.res, "R8 result port", int'(result), e.res);
                    check(rng == e.ovr, "R6 range flag", int'(rng), int'(e.ovr));
                    check(busy_cnt == e.cyc, "R7 busy clocks", busy_cnt, e.cyc);
                    check(!step_bad, "R3 one step per clock", int'(step_bad), 0);
                    check(!busy, "R4 busy dropped", int'(busy), 0);
                end
            end
            prev_eoc  = eoc_n;
            prev_busy = busy;
            prev_code = int'(code);
        end
    end

    task automatic pulse_start(input int hold);
        @(negedge clk);
        start = 1'b1;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check(code == '0, "R2 code cleared under start", int'(code), 0);
        end
        check(!busy && eoc_n, "R2 idle while start high", int'(busy), 0);
        check(result == '0, "R8 result zero while pending", int'(result), 0);
        start = 1'b0;
    endtask

    task automatic convert(input int t);
        exp_t e;
        int   hold_code;
        trip = t;
        if (t <= FULL) begin
            e.res = t; e.ovr = 1'b0; e.cyc = t + 1;
        end else begin
            e.res = FULL; e.ovr = 1'b1; e.cyc = FULL + 1;
        end
        exp_q.push_back(e);
        pulse_start(2);
        for (int i = 0; i < 400 && eoc_n; i++) @(negedge clk);
        @(negedge clk);
        hold_code = int'(code);
        // R5: comparator swings after completion must not move the code
        trip = 0;
        repeat (3) @(negedge clk);
        trip = FULL + 10;
        repeat (3) @(negedge clk);
        check(int'(code) == hold_code && int'(result) == hold_code && !eoc_n,
              "R5 result held", int'(code), hold_code);
    endtask

    // main driver
    initial begin
        repeat (3) @(negedge clk);
        check(code == '0 && result == '0, "R1 reset code", int'(code), 0);
        check(!busy && eoc_n && !rng, "R1 reset flags", int'({busy, eoc_n, rng}), 3'b010);
        rst_n = 1'b1;
        @(negedge clk);
        check(code == '0 && eoc_n && !busy, "R1 after release", int'(code), 0);

        // R2: long start hold with comparator high
        trip = 100;
        pulse_start(5);
        exp_q.push_back('{res: 100, ovr: 1'b0, cyc: 101});
        for (int i = 0; i < 400 && eoc_n; i++) @(negedge clk);
        @(negedge clk);

        convert(0);
        convert(1);
        convert(37);
        convert(128);
        convert(254);
        convert(255);   // trip exactly at full scale, R6 no range flag
        convert(256);   // beyond range, R6
        convert(300);

        // R9: abort mid-conversion
        trip = 200;
        pulse_start(1);
        repeat (20) @(negedge clk);
        check(busy && int'(code) > 0, "R9 counting before abort", int'(code), 19);
        start = 1'b1;
        @(negedge clk);
        check(code == '0 && eoc_n, "R9 cleared by new start", int'(code), 0);
        start = 1'b0;
        exp_q.push_back('{res: 200, ovr: 1'b0, cyc: 201});
        for (int i = 0; i < 400 && eoc_n; i++) @(negedge clk);
        @(negedge clk);
        convert(5);

        check(exp_q.size() == 0, "R4 all completions seen", exp_q.size(), 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule